// File: doc/BRIEF.md
# Bus Wait-State Ready Generator

This block sits on the memory side of a CPU-style local bus and answers each bus cycle with the right ready strobe after a programmable delay. The CPU starts a cycle with a one-clock start strobe and a read/write flag. The generator then holds both active-low ready outputs high for a set number of wait states and asserts one of them to end the transfer. A zero-wait cycle lasts two clocks: the start clock, then one clock at whose end the ready strobe is sampled.

Reads, writes and burst continuation beats each take their own wait-state count. That lets one block produce bus timings such as 2-2, 2-3, 2-1-2 or 2-1-3. During the clock after the start strobe, the block looks at the CPU's active-low last-transfer pin to choose the answer for a read. If the pin is high, the read is answered with burst ready and more beats follow. If it is low, the read is answered with normal ready and ends after one transfer. A burst runs until a beat completes while the last-transfer pin is low.

Top module: `wait_ready_gen`

## Requirements
- R1: While reset is active, and in every idle clock after it, `rdy_n` and `brdy_n` are both high (1).
- R2: When `cyc_start` is sampled high while idle with `wr`=0, the first transfer completes in clock 2+`rd_wait`. Clock 1 is the start clock. The ready strobe is low only in that clock, and both strobes are high in the clocks before it.
- R3: When `wr`=1 is sampled with the start strobe, the single transfer completes in clock 2+`wr_wait` with `rdy_n` low. `brdy_n` stays high throughout the cycle, whatever the level of `last_n`.
- R4: A read whose `last_n` is low (0) in the clock after the start clock completes with `rdy_n` low, never `brdy_n`. The block is then idle in the next clock.
- R5: A read whose `last_n` is high (1) in the clock after the start clock completes its first transfer with `brdy_n` low and `rdy_n` high.
- R6: After a beat that completes with `brdy_n` low and `last_n` high, the next beat completes after `beat_wait` further wait clocks. That is one clock per beat when `beat_wait`=0.
- R7: A burst ends at the beat that completes with `last_n` low. Both strobes are high in the following clock.
- R8: `rd_wait`, `beat_wait`, `wr_wait` and `wr` are captured on the start clock edge. Changes to them during a cycle do not alter its timing or its kind.
- R9: A `cyc_start` that is high while a cycle is in progress is ignored. It neither restarts the wait count nor starts a cycle after the current one ends.
- R10: `rdy_n` and `brdy_n` are never low in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | Cycle start strobe, active high, sampled at the rising edge |
| wr | input | 1 | 1 = write cycle, 0 = read cycle; captured with the start strobe |
| last_n | input | 1 | CPU last-transfer pin, active low |
| rd_wait | input | 3 | Wait states before the first read transfer |
| beat_wait | input | 3 | Wait states before each later burst beat |
| wr_wait | input | 3 | Wait states for a write |
| rdy_n | output | 1 | Normal ready, active low |
| brdy_n | output | 1 | Burst ready, active low |

## Verification
The bench compares both strobes against a clock-by-clock expectation. The first case is the zero-wait and maximum-wait extremes of each count: an off-by-one counter would assert ready one clock early or late. The second is a write with the last-transfer pin held high: a design that failed to separate writes from reads would answer it with burst ready. The third is a burst whose last beat has its own timing, in both 2-1-2 and slower settings: a design that stopped at the wrong beat or reloaded the wrong count would miss or add a beat. The fourth is a cycle in which the start strobe stays high and every configuration input and the write flag change partway through: a design that did not latch them, or that restarted on the strobe, would change the timing or launch a stray cycle.

// File: rtl/wait_ready_gen.sv
module wait_ready_gen #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_start,
  input  logic          wr,
  input  logic          last_n,
  input  logic [CW-1:0] rd_wait,
  input  logic [CW-1:0] beat_wait,
  input  logic [CW-1:0] wr_wait,
  output logic          rdy_n,
  output logic          brdy_n
);

  logic          busy, first, burst_ok, wr_q;
  logic [CW-1:0] cnt, beat_q;

  wire done      = busy && (cnt == '0);
  wire burst_sel = !wr_q && (first ? last_n : burst_ok);

  assign brdy_n = !(done && burst_sel);
  assign rdy_n  = !(done && !burst_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      first    <= 1'b0;
      burst_ok <= 1'b0;
      wr_q     <= 1'b0;
      cnt      <= '0;
      beat_q   <= '0;
    end else if (!busy) begin
      if (cyc_start) begin
        busy   <= 1'b1;
        first  <= 1'b1;
        wr_q   <= wr;
        cnt    <= wr ? wr_wait : rd_wait;
        beat_q <= beat_wait;
      end
    end else begin
      first <= 1'b0;
      if (first) burst_ok <= !wr_q && last_n;
      if (cnt != '0)
        cnt <= cnt - 1'b1;
      else if (!brdy_n && last_n)
        cnt <= beat_q;
      else
        busy <= 1'b0;
    end
  end

  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rdy_n && !brdy_n)); // R10
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rdy_n && brdy_n)); // R1
  AST_WRITE_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_q) |-> brdy_n); // R3
  AST_NORMAL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_n |=> (rdy_n && brdy_n)); // R4
  AST_LAST_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (!brdy_n && !last_n) |=> (rdy_n && brdy_n)); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cyc_start && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1)); // R9

endmodule

// File: tb/test_wait_ready_gen.sv
module test_wait_ready_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_start = 1'b0, wr = 1'b0, last_n = 1'b1;
  logic [2:0] rd_wait = '0, beat_wait = '0, wr_wait = '0;
  logic rdy_n, brdy_n;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  wait_ready_gen i_wait_ready_gen (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .wr(wr), .last_n(last_n),
    .rd_wait(rd_wait), .beat_wait(beat_wait), .wr_wait(wr_wait),
    .rdy_n(rdy_n), .brdy_n(brdy_n));

  task automatic expect_out(input logic er, input logic eb, input string tag);
    checks++;
    if (rdy_n !== er || brdy_n !== eb) begin
      fails++;
      $display("FAIL %s: rdy_n/brdy_n = %b/%b expected %b/%b at %0t",
               tag, rdy_n, brdy_n, er, eb, $time);
    end
    checks++;
    if (rdy_n === 1'b0 && brdy_n === 1'b0) begin
      fails++;
      $display("FAIL R10: rdy_n/brdy_n = 0/0 expected not both low at %0t", $time);
    end
  endtask

  // One full bus cycle with clock-by-clock expectations.
  task automatic do_cycle(input logic w, input int rdw, input int bw, input int ww,
                          input int beats, input bit noise, input string tag);
    bit burst = !w && beats > 1;
    int n = w ? 1 : beats;
    @(negedge clk);
    wr = w; rd_wait = 3'(rdw); beat_wait = 3'(bw); wr_wait = 3'(ww);
    cyc_start = 1'b1; last_n = 1'b1;
    #1 expect_out(1'b1, 1'b1, "R1");
    for (int t = 0; t < n; t++) begin
      int waits = (t == 0) ? (w ? ww : rdw) : bw;
      for (int k = 0; k <= waits; k++) begin
        @(negedge clk);
        cyc_start = noise;
        if (noise) begin
          wr = ~w; rd_wait = ~3'(rdw); beat_wait = ~3'(bw); wr_wait = ~3'(ww);
        end
        last_n = w ? 1'b1 : ((t == n - 1) ? 1'b0 : 1'b1);
        #1;
        if (k < waits) expect_out(1'b1, 1'b1, tag);
        else if (burst) expect_out(1'b1, 1'b0, tag);
        else expect_out(1'b0, 1'b1, tag);
      end
    end
    @(negedge clk);
    cyc_start = 1'b0; last_n = 1'b1;
    #1 expect_out(1'b1, 1'b1, burst ? "R7" : "R4");
  endtask

  task automatic test_reset;
    cyc_start = 1'b1;
    repeat (3) @(negedge clk);
    #1 expect_out(1'b1, 1'b1, "R1");
    cyc_start = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    #1 expect_out(1'b1, 1'b1, "R1");
  endtask

  task automatic test_single_reads;
    do_cycle(1'b0, 0, 0, 0, 1, 1'b0, "R2 R4 zero wait");
    do_cycle(1'b0, 1, 5, 5, 1, 1'b0, "R2 R4 one wait");
    do_cycle(1'b0, 7, 0, 0, 1, 1'b0, "R2 R4 seven waits");
  endtask

  task automatic test_writes;
    do_cycle(1'b1, 3, 3, 0, 1, 1'b0, "R3 zero wait");
    do_cycle(1'b1, 0, 0, 1, 4, 1'b0, "R3 one wait");
    do_cycle(1'b1, 0, 0, 7, 1, 1'b0, "R3 seven waits");
  endtask

  task automatic test_bursts;
    do_cycle(1'b0, 0, 0, 0, 4, 1'b0, "R5 R6 2-1 burst");
    do_cycle(1'b0, 1, 2, 0, 3, 1'b0, "R5 R6 slow burst");
    do_cycle(1'b0, 7, 7, 0, 2, 1'b0, "R5 R6 max burst");
  endtask

  task automatic test_mixed_timing;
    do_cycle(1'b0, 0, 0, 1, 4, 1'b0, "R6 2-1-3 read");
    do_cycle(1'b1, 0, 0, 1, 1, 1'b0, "R3 2-1-3 write");
    do_cycle(1'b0, 0, 0, 1, 1, 1'b0, "R4 2-1-3 single");
  endtask

  task automatic test_latch_and_ignore;
    do_cycle(1'b0, 2, 1, 6, 3, 1'b1, "R8 R9 burst noise");
    do_cycle(1'b1, 5, 5, 2, 1, 1'b1, "R8 R9 write noise");
    do_cycle(1'b0, 3, 0, 0, 1, 1'b1, "R8 R9 read noise");
    @(negedge clk);
    #1 expect_out(1'b1, 1'b1, "R9 no stray cycle");
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog: run incomplete expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    test_reset;
    test_single_reads;
    test_writes;
    test_bursts;
    test_mixed_timing;
    test_latch_and_ignore;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule